// File: doc/BRIEF.md
# Motion-Sensor Register Read Port with Sample Snapshot

This block is the register-access half of a motion-sensor serial slave, working at byte level. A bus front end, which is not part of this block, decodes the serial traffic into single-cycle events. These are a start or repeated start, a written byte, a request for one read byte, and a stop or bus-idle indication. The block answers each read request with one byte.

Seven live 16-bit sample words come from an acquisition stub:

- accelerometer X, Y and Z,
- temperature,
- gyroscope X, Y and Z.

These words are copied into a shadow store only when the bus goes idle. A multi-byte burst therefore always returns data from a single sampling instant.

Next to the sample block, the block serves a byte FIFO through a data port that never advances the pointer. It also exposes the FIFO fill level as two count registers. The pointer moves in a different way for each of these address regions.

Top module: `sensor_regport`

## Requirements
- R1: After reset, `rd_byte` is 0x00, `rd_valid` is 0, the register pointer is 0x00 (an unmapped address) and the FIFO is empty, so both count registers read 0x00.
- R2: The 14-byte sample block begins at address 0x3B and holds seven words in this order: accelerometer X, Y, Z, temperature, gyroscope X, Y, Z. Each word is stored with its high byte at the lower address. Word k enters on `live_words[16k+15:16k]`.
- R3: A read at an address inside the sample block advances the pointer by one, so a 14-byte burst from 0x3B returns every sample byte in address order.
- R4: At the last sample address (0x48) the pointer stops advancing, and further reads in the burst return that byte again.
- R5: The shadow copy takes all seven live words in the single cycle of an `ev_idle` pulse, and at no other time. Live changes made during a transaction are not seen until the next idle.
- R6: The first byte written after a start loads the pointer, and later written bytes in that transaction are ignored. A read that follows a repeated start begins at the loaded pointer.
- R7: The FIFO data port at 0x74 never advances the pointer. Each read there pops one byte, oldest first.
- R8: A read of the FIFO data port while the FIFO is empty returns 0x00, and the count stays 0.
- R9: The FIFO fill level is a 16-bit count, with its high byte at 0x72 and its low byte at 0x73. Neither address advances the pointer, so a two-byte burst from 0x72 returns the high byte twice.
- R10: A push into a full FIFO (FIFO_DEPTH bytes, 16 by default) is dropped, and the count stays at FIFO_DEPTH.
- R11: A read at any unmapped address returns 0x00 and leaves the pointer unchanged.
- R12: `rd_valid` is high for exactly the cycle after an `ev_rd` pulse, and `rd_byte` holds the answer during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_wbyte | input | 1 | A write-direction data byte was received |
| wr_byte | input | 8 | Value of the written byte |
| ev_rd | input | 1 | Master requests one read byte |
| ev_idle | input | 1 | Stop or bus-idle detected |
| live_words | input | 112 | Live sample words, word k at bits 16k+15:16k |
| fifo_push | input | 1 | Acquisition stub pushes one FIFO byte |
| fifo_din | input | 8 | Byte pushed into the FIFO |
| rd_byte | output | 8 | Answer to the previous read request |
| rd_valid | output | 1 | rd_byte is valid this cycle |

## Verification
Distinct, known word values are driven into the sample block, and a 14-byte burst is checked against a table. This shows whether byte order, word order and pointer advance are all correct, and the burst is then run past the end to show the pointer stops at the last byte. The live words are changed in the middle of a burst, which separates a snapshot taken at idle from a live pass-through. The FIFO is driven empty, partly filled and overfilled. Its data port and count registers are read both as bursts and as single bytes, which tells a non-advancing port apart from an auto-incrementing one and exposes the duplicated high count byte.

// File: rtl/sregp_pkg.sv
package sregp_pkg;
   localparam int ADDR_W = 8;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_SAMPLE,
      SRC_FIFO,
      SRC_CNT_HI,
      SRC_CNT_LO
   } rd_src_e;
endpackage

// File: rtl/sregp_shadow.sv
module sregp_shadow #(
   parameter int N_WORDS = 7,
   parameter int WORD_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      refresh,
   input  logic [N_WORDS*WORD_W-1:0] live,
   output logic [N_WORDS*WORD_W-1:0] snap
);
   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            snap[w*WORD_W +: WORD_W] <= '0;
         else if (refresh)
            snap[w*WORD_W +: WORD_W] <= live[w*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/sregp_fifo.sv
module sregp_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("sregp_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          push_ok, pop_ok;

   assign push_ok = push && (count != CW'(DEPTH));
   assign pop_ok  = pop && (count != '0);
   assign head    = (count == '0) ? '0 : mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= wp + PW'(1);
         if (pop_ok)  rp <= rp + PW'(1);
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end
endmodule

// File: rtl/sregp_ptr.sv
module sregp_ptr
   import sregp_pkg::*;
#(
   parameter logic [ADDR_W-1:0] SAMPLE_BASE = 8'h3B,
   parameter int                NBYTES      = 14,
   parameter logic [ADDR_W-1:0] FIFO_ADDR   = 8'h74,
   parameter logic [ADDR_W-1:0] CNT_HI_ADDR = 8'h72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_wbyte,
   input  logic [ADDR_W-1:0] wr_byte,
   input  logic              ev_rd,
   output logic [ADDR_W-1:0] ptr,
   output rd_src_e           src,
   output logic              pop
);
   localparam logic [ADDR_W-1:0] LAST = SAMPLE_BASE + ADDR_W'(NBYTES - 1);

   logic want_ptr;

   always_comb begin
      if (ptr >= SAMPLE_BASE && ptr <= LAST) src = SRC_SAMPLE;
      else if (ptr == FIFO_ADDR)             src = SRC_FIFO;
      else if (ptr == CNT_HI_ADDR)           src = SRC_CNT_HI;
      else if (ptr == CNT_HI_ADDR + 8'd1)    src = SRC_CNT_LO;
      else                                   src = SRC_NONE;
   end

   assign pop = ev_rd && (src == SRC_FIFO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         want_ptr <= 1'b0;
      end else begin
         if (ev_start)               want_ptr <= 1'b1;
         else if (ev_wbyte || ev_rd) want_ptr <= 1'b0;

         if (ev_wbyte && want_ptr)
            ptr <= wr_byte;
         else if (ev_rd && src == SRC_SAMPLE && ptr != LAST)
            ptr <= ptr + 8'd1;
      end
   end
endmodule

// File: rtl/sensor_regport.sv
module sensor_regport
   import sregp_pkg::*;
#(
   parameter int                N_WORDS        = 7,
   parameter int                WORD_W         = 16,
   parameter logic [ADDR_W-1:0] SAMPLE_BASE    = 8'h3B,
   parameter logic [ADDR_W-1:0] FIFO_DATA_ADDR = 8'h74,
   parameter logic [ADDR_W-1:0] CNT_HI_ADDR    = 8'h72,
   parameter int                FIFO_DEPTH     = 16,
   localparam int               NBYTES         = N_WORDS * WORD_W / BYTE_W,
   localparam int               CW             = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ev_start,
   input  logic                      ev_wbyte,
   input  logic [7:0]                wr_byte,
   input  logic                      ev_rd,
   input  logic                      ev_idle,
   input  logic [N_WORDS*WORD_W-1:0] live_words,
   input  logic                      fifo_push,
   input  logic [7:0]                fifo_din,
   output logic [7:0]                rd_byte,
   output logic                      rd_valid
);
   if (WORD_W != 16) begin : g_bad_word
      $error("sensor_regport: WORD_W must be 16");
   end
   if (int'(SAMPLE_BASE) + NBYTES > 256) begin : g_bad_base
      $error("sensor_regport: sample block exceeds address space");
   end

   logic [N_WORDS*WORD_W-1:0] snap;
   logic [ADDR_W-1:0]         ptr_q;
   rd_src_e                   src;
   logic                      pop;
   logic [7:0]                fifo_head;
   logic [CW-1:0]             fifo_cnt;
   logic [15:0]               cnt16;
   logic [ADDR_W-1:0]         offs;
   logic [7:0]                sample_byte;
   logic [7:0]                sel_byte;

   sregp_shadow #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .refresh(ev_idle), .live(live_words), .snap(snap)
   );

   sregp_ptr #(
      .SAMPLE_BASE(SAMPLE_BASE), .NBYTES(NBYTES),
      .FIFO_ADDR(FIFO_DATA_ADDR), .CNT_HI_ADDR(CNT_HI_ADDR)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_wbyte(ev_wbyte),
      .wr_byte(wr_byte), .ev_rd(ev_rd), .ptr(ptr_q), .src(src), .pop(pop)
   );

   sregp_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_din),
      .pop(pop), .head(fifo_head), .count(fifo_cnt)
   );

   assign offs  = ptr_q - SAMPLE_BASE;
   assign cnt16 = 16'(fifo_cnt);

   always_comb begin
      sample_byte = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (offs == ADDR_W'(i))
            sample_byte = snap[(i / 2) * WORD_W + ((i % 2) != 0 ? 0 : 8) +: 8];
      end
   end

   always_comb begin
      case (src)
         SRC_SAMPLE: sel_byte = sample_byte;
         SRC_FIFO:   sel_byte = fifo_head;
         SRC_CNT_HI: sel_byte = cnt16[15:8];
         SRC_CNT_LO: sel_byte = cnt16[7:0];
         default:    sel_byte = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_byte  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= ev_rd;
         if (ev_rd) rd_byte <= sel_byte;
      end
   end
endmodule

// File: rtl/sregp_chk.sv
module sregp_chk #(
   parameter logic [7:0] SAMPLE_BASE = 8'h3B,
   parameter int         NBYTES      = 14,
   parameter logic [7:0] FIFO_ADDR   = 8'h74,
   parameter int         FIFO_DEPTH  = 16,
   parameter int         SNAP_W      = 112,
   parameter int         CW          = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_rd,
   input logic              ev_wbyte,
   input logic              ev_idle,
   input logic              fifo_push,
   input logic [7:0]        ptr,
   input logic [SNAP_W-1:0] snap,
   input logic [CW-1:0]     cnt,
   input logic [7:0]        rd_byte,
   input logic              rd_valid
);
   localparam logic [7:0] LAST = SAMPLE_BASE + 8'(NBYTES - 1);

   // R12
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd |=> rd_valid);
   // R12
   rvalid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_rd |=> !rd_valid);
   // R5
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_idle |=> $stable(snap));
   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !ev_wbyte && ptr >= SAMPLE_BASE && ptr < LAST) |=> ptr == $past(ptr) + 8'd1);
   // R4
   ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !ev_wbyte && ptr == LAST) |=> ptr == LAST);
   // R7
   fifo_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !ev_wbyte && ptr == FIFO_ADDR) |=> ptr == FIFO_ADDR);
   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(FIFO_DEPTH));
   // R8
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && ptr == FIFO_ADDR && cnt == '0 && !fifo_push) |=> (rd_byte == 8'h00 && cnt == '0));
endmodule

bind sensor_regport sregp_chk #(
   .SAMPLE_BASE(SAMPLE_BASE), .NBYTES(NBYTES), .FIFO_ADDR(FIFO_DATA_ADDR),
   .FIFO_DEPTH(FIFO_DEPTH), .SNAP_W(N_WORDS*WORD_W), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_rd(ev_rd), .ev_wbyte(ev_wbyte), .ev_idle(ev_idle),
   .fifo_push(fifo_push), .ptr(ptr_q), .snap(snap), .cnt(fifo_cnt),
   .rd_byte(rd_byte), .rd_valid(rd_valid)
);

// File: tb/sim_sensor_regport.sv
`timescale 1ns/1ps
module sim_sensor_regport;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ev_start = 1'b0, ev_wbyte = 1'b0, ev_rd = 1'b0, ev_idle = 1'b0;
   logic [7:0]   wr_byte = '0;
   logic [111:0] live_words = '0;
   logic         fifo_push = 1'b0;
   logic [7:0]   fifo_din = '0;
   logic [7:0]   rd_byte;
   logic         rd_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   localparam logic [7:0] EXP_BURST [14] = '{
      8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
      8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE };

   always #2.5 clk = ~clk;

   sensor_regport u0 (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_wbyte(ev_wbyte),
      .wr_byte(wr_byte), .ev_rd(ev_rd), .ev_idle(ev_idle), .live_words(live_words),
      .fifo_push(fifo_push), .fifo_din(fifo_din), .rd_byte(rd_byte), .rd_valid(rd_valid)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) ev_start = 1'b1;
      @(negedge clk) ev_start = 1'b0;
   endtask

   task automatic pulse_idle();
      @(negedge clk) ev_idle = 1'b1;
      @(negedge clk) ev_idle = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk) begin ev_wbyte = 1'b1; wr_byte = b; end
      @(negedge clk) ev_wbyte = 1'b0;
   endtask

   task automatic read_byte(output logic [7:0] b);
      @(negedge clk) ev_rd = 1'b1;
      @(negedge clk) ev_rd = 1'b0;
      b = rd_byte;
      if (rd_valid !== 1'b1) begin
         n_checks++; n_fail++;
         $display("FAIL R12: actual rd_valid %b expected 1", rd_valid);
      end
   endtask

   task automatic push_byte(input logic [7:0] b);
      @(negedge clk) begin fifo_push = 1'b1; fifo_din = b; end
      @(negedge clk) fifo_push = 1'b0;
   endtask

   task automatic single_read(input logic [7:0] addr, output logic [7:0] b);
      pulse_start();
      write_byte(addr);
      pulse_start();
      read_byte(b);
      pulse_idle();
   endtask

   function automatic logic [111:0] pack7(input logic [15:0] w0, w1, w2, w3, w4, w5, w6);
      return {w6, w5, w4, w3, w2, w1, w0};
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rd_byte", rd_byte, 8'h00);
      check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
      pulse_start(); read_byte(b); pulse_idle();
      check("R1 pointer at unmapped", b, 8'h00);
      single_read(8'h73, b); check("R1 count low", b, 8'h00);
      @(negedge clk);
      check("R12 rd_valid drops", {7'd0, rd_valid}, 8'h00);

      // R2 R3 table-driven burst
      live_words = pack7(16'h1122, 16'h3344, 16'h5566, 16'h7788,
                         16'h99AA, 16'hBBCC, 16'hDDEE);
      pulse_idle();
      pulse_start(); write_byte(8'h3B); pulse_start();
      for (int i = 0; i < 14; i++) begin
         read_byte(b);
         check($sformatf("R2 R3 burst byte %0d", i), b, EXP_BURST[i]);
      end
      // R4 saturate at last byte
      read_byte(b); check("R4 past end", b, 8'hEE);
      read_byte(b); check("R4 past end again", b, 8'hEE);
      pulse_idle();

      // R5 coherence within transaction
      pulse_start(); write_byte(8'h3B); pulse_start();
      read_byte(b); check("R5 first byte", b, 8'h11);
      live_words = pack7(16'hA1A2, 16'hB1B2, 16'hC1C2, 16'hD1D2,
                         16'hE1E2, 16'hF1F2, 16'h0102);
      repeat (3) @(negedge clk);
      read_byte(b); check("R5 old sample held", b, 8'h22);
      pulse_idle();
      single_read(8'h3B, b); check("R5 refreshed after idle", b, 8'hA1);

      // R6 pointer load by first written byte only
      pulse_start(); write_byte(8'h41); write_byte(8'h3B);
      pulse_start(); read_byte(b); check("R6 repeated start read", b, 8'hD1);
      read_byte(b); check("R6 next byte", b, 8'hD2);
      pulse_idle();

      // R11 unmapped
      pulse_start(); write_byte(8'h10); pulse_start();
      read_byte(b); check("R11 unmapped", b, 8'h00);
      read_byte(b); check("R11 unmapped repeat", b, 8'h00);
      pulse_idle();

      // R9 R7 R8 FIFO
      push_byte(8'hC5); push_byte(8'hC6); push_byte(8'hC7);
      single_read(8'h73, b); check("R9 count low", b, 8'h03);
      single_read(8'h72, b); check("R9 count high", b, 8'h00);
      pulse_start(); write_byte(8'h72); pulse_start();
      read_byte(b); check("R9 burst first", b, 8'h00);
      read_byte(b); check("R9 burst repeats high", b, 8'h00);
      pulse_idle();
      pulse_start(); write_byte(8'h74); pulse_start();
      read_byte(b); check("R7 pop 1", b, 8'hC5);
      read_byte(b); check("R7 pop 2", b, 8'hC6);
      read_byte(b); check("R7 pop 3", b, 8'hC7);
      read_byte(b); check("R8 empty pop", b, 8'h00);
      pulse_idle();
      single_read(8'h73, b); check("R8 count stays 0", b, 8'h00);

      // R10 overfill
      for (int i = 0; i < 18; i++) push_byte(8'h40 + 8'(i));
      single_read(8'h73, b); check("R10 count saturates", b, 8'h10);
      pulse_start(); write_byte(8'h74); pulse_start();
      for (int i = 0; i < 16; i++) begin
         read_byte(b);
         check($sformatf("R10 R7 drain %0d", i), b, 8'h40 + 8'(i));
      end
      read_byte(b); check("R10 extra pushes dropped", b, 8'h00);
      pulse_idle();

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule